// File: doc/BRIEF.md
# DisplayPort AUX transaction buffer

This block stages one AUX request in a small transmit store, plays it out byte by byte to a line model once started, and then collects the sink's reply into a receive store. The host drives it through four word registers. Register 0 (control) holds the byte count, the go bit and the reply timeout. Register 1 is the data port, register 2 is the status word and register 3 is the done-acknowledge register. A read of register 0 returns the control fields. A read of any other address except the data port returns the status word.

The host composes the request itself. Byte 0 carries the request command in bits 7:4. Bytes 1 and 2 carry the address, high byte first. When the payload length is nonzero, byte 3 carries the length minus one; an address-only request stops after the three address bytes. Write commands follow the header with up to 16 payload bytes; read commands send no payload. After the go bit is accepted, the host polls status for the done flag, the error flags and the reply count. It then rewinds the data port and reads the reply back. The first reply byte is the acknowledge byte, with the reply code in its upper nibble.

The line side is a byte stream. Each `tx_valid` cycle carries one request byte. `rx_valid` delivers reply bytes, with `rx_end` marking the last one. `rx_err` carries receive fault indications such as overflow on the wire, disconnect, partial byte, and bad start, stop or sync.

Top module: `aux_xbuf`

## Requirements
- R1: Once a go is accepted on the edge at cycle N, `tx_valid` is high from cycle N+2 for exactly COUNT consecutive cycles. `tx_byte` carries staging slots 0, 1, 2 and so on, in that order. `tx_last` is high only together with the final byte.
- R2: A data-port write (address 1, bit 30 clear) stores bits 7:0 in a staging slot. If bit 31 is set, the byte goes to slot 0; otherwise it goes to the slot after the last one written. Slots 20 and beyond are never written.
- R3: A control write with go (bit 8) set is ignored when COUNT (bits 4:0) is 0 or greater than 20, which is 4 header bytes plus 16 payload bytes. No byte is sent and busy stays low.
- R4: A control write while a transaction is in progress starts nothing. It also leaves the stored COUNT and timeout unchanged.
- R5: The go bit is not stored, so control readback bit 8 is always 0. Status bit 1 (busy) is high from the accepted go until the transaction completes. Register read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R6: When a reply byte arrives with `rx_end` set, status bit 0 (done) sets. At the same moment busy clears, and status bits 28:24 hold the number of reply bytes received.
- R7: A data-port write with bit 30 set rewinds the reply read pointer and stores nothing. Each later data-port read returns the next reply byte in bits 15:8, with all other bits zero. The first byte returned is the acknowledge byte.
- R8: Let L be control bits 31:16. If no reply byte arrives within L+1 cycles after the last request byte, done and status bit 2 (timeout) set together and the reply count is 0.
- R9: Reply bytes beyond the 17th are discarded. They set status bit 3 (overflow), the count stays 17, and the first 17 bytes read back intact.
- R10: `rx_err` bits seen while waiting for or receiving a reply are OR-ed into status bits 8:4. An accepted go clears these bits, together with done, timeout, overflow and the reply count.
- R11: Writing 1 to bit 0 of register 3 clears done and leaves every other status field unchanged.
- R12: After reset the status word reads 0 and `tx_valid` and `tx_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, cycle after `reg_rd` |
| tx_valid | output | 1 | Request byte valid |
| tx_byte | output | 8 | Request byte |
| tx_last | output | 1 | Final request byte |
| rx_valid | input | 1 | Reply byte valid |
| rx_byte | input | 8 | Reply byte |
| rx_end | input | 1 | Final reply byte |
| rx_err | input | LERR_W (5) | Receive fault indications |

## Verification
The bench carries a cycle model that decides, for every edge, what the line outputs must be on the following cycle. The first request byte is due two edges after the accepted control write: one edge to enter the send phase and one through the staging store's registered read port. Every later byte follows one cycle apart, and the line outputs are compared at each falling edge. Read results are due one cycle after `reg_rd` and are compared against the model's register values from before that edge. The timeout fires exactly L+1 edges after the edge that sent the last byte. Status polls are placed well after that point, so the model and the explicit field checks agree on when done must already be visible.

// File: rtl/aux_xbuf_pkg.sv
package aux_xbuf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RECV = 2'd3
  } xstate_t;

  // register map
  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_DATA = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_ACK  = 2'd3;

  // control / data-port bit positions
  localparam int GO_BIT      = 8;
  localparam int TMO_LSB     = 16;
  localparam int RD_MODE_BIT = 30;
  localparam int PTR_RST_BIT = 31;
  localparam int ACK_BIT     = 0;

  // status word layout
  localparam int SB_DONE = 0;
  localparam int SB_BUSY = 1;
  localparam int SB_TMO  = 2;
  localparam int SB_OVF  = 3;
  localparam int SB_LERR = 4;
  localparam int SB_RCNT = 24;

endpackage

// File: rtl/aux_xbuf_ram.sv
// Byte store with one write port and one registered read port.
module aux_xbuf_ram #(
  parameter int DEPTH = 20,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= (raddr <= LAST) ? mem[raddr] : 8'h00;
  end
endmodule

// File: rtl/aux_xbuf_seq.sv
// Transaction sequencer: send phase, reply wait with timeout, reply capture.
module aux_xbuf_seq
  import aux_xbuf_pkg::*;
#(
  parameter int RX_DEPTH = 17,
  parameter int CNT_W    = 5,
  parameter int RCNT_W   = 5,
  parameter int TMO_W    = 16,
  parameter int LERR_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  req_cnt,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              rx_valid,
  input  logic              rx_end,
  input  logic [LERR_W-1:0] rx_err,
  input  logic              done_ack,
  output logic              busy,
  output logic [CNT_W-1:0]  tx_idx,
  output logic              tx_valid,
  output logic              tx_last,
  output logic              rx_we,
  output logic [RCNT_W-1:0] rx_waddr,
  output logic              done,
  output logic              tmo_flag,
  output logic              ovf_flag,
  output logic [LERR_W-1:0] lerr,
  output logic [RCNT_W-1:0] rcnt
);
  localparam logic [RCNT_W-1:0] RX_FULL = RCNT_W'(RX_DEPTH);

  xstate_t           state;
  logic [CNT_W-1:0]  cnt_q;
  logic [TMO_W-1:0]  tcnt;

  assign busy     = (state != ST_IDLE);
  assign rx_we    = rx_valid && ((state == ST_WAIT) ||
                                 ((state == ST_RECV) && (rcnt != RX_FULL)));
  assign rx_waddr = rcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt_q    <= '0;
      tx_idx   <= '0;
      tcnt     <= '0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      done     <= 1'b0;
      tmo_flag <= 1'b0;
      ovf_flag <= 1'b0;
      lerr     <= '0;
      rcnt     <= '0;
    end else begin
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      if (done_ack) done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_SEND;
            cnt_q    <= req_cnt;
            tx_idx   <= '0;
            done     <= 1'b0;
            tmo_flag <= 1'b0;
            ovf_flag <= 1'b0;
            lerr     <= '0;
            rcnt     <= '0;
          end
        end
        ST_SEND: begin
          tx_valid <= 1'b1;
          tx_idx   <= tx_idx + 1'b1;
          if (tx_idx == cnt_q - 1'b1) begin
            tx_last <= 1'b1;
            tcnt    <= '0;
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          lerr <= lerr | rx_err;
          if (rx_valid) begin
            rcnt <= RCNT_W'(1);
            if (rx_end) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_RECV;
            end
          end else if (tcnt == tmo_limit) begin
            done     <= 1'b1;
            tmo_flag <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_RECV: begin
          lerr <= lerr | rx_err;
          if (rx_valid) begin
            if (rcnt == RX_FULL) ovf_flag <= 1'b1;
            else                 rcnt     <= rcnt + 1'b1;
            if (rx_end) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_xbuf.sv
// AUX request/reply buffer: host register port, staging stores, sequencer.
module aux_xbuf
  import aux_xbuf_pkg::*;
#(
  parameter int TX_DEPTH = 20,
  parameter int RX_DEPTH = 17,
  parameter int TMO_W    = 16,
  parameter int LERR_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              tx_last,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_end,
  input  logic [LERR_W-1:0] rx_err
);
  localparam int CNT_W  = $clog2(TX_DEPTH + 1);
  localparam int TAW    = $clog2(TX_DEPTH);
  localparam int RCNT_W = $clog2(RX_DEPTH + 1);
  localparam int RAW    = $clog2(RX_DEPTH);

  logic              busy, done, tmo_flag, ovf_flag, rx_we;
  logic [CNT_W-1:0]  tx_idx;
  logic [RCNT_W-1:0] rcnt, rx_waddr;
  logic [LERR_W-1:0] lerr;

  logic [CNT_W-1:0]  tx_wptr, cnt_q, wr_slot, req_cnt;
  logic [TMO_W-1:0]  tmo_q;
  logic [RCNT_W-1:0] rx_rptr;
  logic [1:0]        rd_sel_q;
  logic [31:0]       rd_snap_q, status_w, ctrl_w;
  logic [7:0]        rx_q;
  logic              wr_ctrl, wr_data, rd_data, done_ack, start, cnt_ok, slot_ok, tx_we;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_data  = reg_wr && (reg_addr == RA_DATA);
  assign rd_data  = reg_rd && (reg_addr == RA_DATA);
  assign done_ack = reg_wr && (reg_addr == RA_ACK) && reg_wdata[ACK_BIT];

  assign req_cnt  = reg_wdata[CNT_W-1:0];
  assign cnt_ok   = (req_cnt != '0) && (req_cnt <= CNT_W'(TX_DEPTH));
  assign start    = wr_ctrl && reg_wdata[GO_BIT] && !busy && cnt_ok;

  assign wr_slot  = reg_wdata[PTR_RST_BIT] ? '0 : tx_wptr;
  assign slot_ok  = wr_slot < CNT_W'(TX_DEPTH);
  assign tx_we    = wr_data && !reg_wdata[RD_MODE_BIT] && slot_ok;

  always_comb begin
    status_w                    = '0;
    status_w[SB_DONE]           = done;
    status_w[SB_BUSY]           = busy;
    status_w[SB_TMO]            = tmo_flag;
    status_w[SB_OVF]            = ovf_flag;
    status_w[SB_LERR +: LERR_W] = lerr;
    status_w[SB_RCNT +: RCNT_W] = rcnt;
    ctrl_w                      = '0;
    ctrl_w[CNT_W-1:0]           = cnt_q;
    ctrl_w[TMO_LSB +: TMO_W]    = tmo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_wptr   <= '0;
      cnt_q     <= '0;
      tmo_q     <= '0;
      rx_rptr   <= '0;
      rd_sel_q  <= RA_STAT;
      rd_snap_q <= '0;
    end else begin
      if (tx_we) tx_wptr <= wr_slot + 1'b1;
      if (wr_data && reg_wdata[RD_MODE_BIT]) rx_rptr <= '0;
      else if (rd_data)                      rx_rptr <= rx_rptr + 1'b1;
      if (wr_ctrl && !busy) begin
        cnt_q <= req_cnt;
        tmo_q <= reg_wdata[TMO_LSB +: TMO_W];
      end
      if (reg_rd) begin
        rd_sel_q  <= reg_addr;
        rd_snap_q <= (reg_addr == RA_CTRL) ? ctrl_w : status_w;
      end
    end
  end

  assign reg_rdata = (rd_sel_q == RA_DATA) ? {16'h0000, rx_q, 8'h00} : rd_snap_q;

  aux_xbuf_ram #(.DEPTH(TX_DEPTH), .AW(TAW)) tx_ram_i (
    .clk  (clk),
    .we   (tx_we),
    .waddr(wr_slot[TAW-1:0]),
    .wdata(reg_wdata[7:0]),
    .raddr(tx_idx[TAW-1:0]),
    .rdata(tx_byte)
  );

  aux_xbuf_ram #(.DEPTH(RX_DEPTH), .AW(RAW)) rx_ram_i (
    .clk  (clk),
    .we   (rx_we),
    .waddr(rx_waddr[RAW-1:0]),
    .wdata(rx_byte),
    .raddr(rx_rptr[RAW-1:0]),
    .rdata(rx_q)
  );

  aux_xbuf_seq #(
    .RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W), .RCNT_W(RCNT_W),
    .TMO_W(TMO_W), .LERR_W(LERR_W)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .req_cnt  (req_cnt),
    .tmo_limit(tmo_q),
    .rx_valid (rx_valid),
    .rx_end   (rx_end),
    .rx_err   (rx_err),
    .done_ack (done_ack),
    .busy     (busy),
    .tx_idx   (tx_idx),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .rx_we    (rx_we),
    .rx_waddr (rx_waddr),
    .done     (done),
    .tmo_flag (tmo_flag),
    .ovf_flag (ovf_flag),
    .lerr     (lerr),
    .rcnt     (rcnt)
  );
endmodule

// File: rtl/aux_xbuf_chk.sv
// Property checker attached to aux_xbuf.
module aux_xbuf_chk #(
  parameter int RX_DEPTH = 17
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             busy,
  input logic                             done,
  input logic                             tmo_flag,
  input logic                             ovf_flag,
  input logic                             tx_valid,
  input logic                             tx_last,
  input logic [$clog2(RX_DEPTH + 1)-1:0]  rcnt
);
  assert_tx_in_busy_R1: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  assert_last_valid_R1: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  assert_no_done_busy_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy);

  assert_tmo_empty_R8: assert property (@(posedge clk) disable iff (rst)
    tmo_flag |-> (rcnt == 0));

  assert_cap_R9: assert property (@(posedge clk) disable iff (rst)
    rcnt <= RX_DEPTH);

  assert_ovf_full_R9: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> (rcnt == RX_DEPTH));
endmodule

bind aux_xbuf aux_xbuf_chk #(.RX_DEPTH(RX_DEPTH)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .tmo_flag(tmo_flag),
  .ovf_flag(ovf_flag),
  .tx_valid(tx_valid),
  .tx_last (tx_last),
  .rcnt    (rcnt)
);

// File: tb/aux_xbuf_tb_top.sv
`timescale 1ns/1ps
module aux_xbuf_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_byte;
  logic        rx_valid, rx_end;
  logic [7:0]  rx_byte;
  logic [4:0]  rx_err;

  always #2.5 clk = ~clk;

  aux_xbuf dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_last(tx_last), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_end(rx_end), .rx_err(rx_err)
  );

  int    n_vec = 0, n_bad = 0;
  string cur = "R12";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_txb [0:31];
  logic [7:0]  m_rxb [0:31];
  int          ms, m_wptr, m_cnt, m_tmo, m_idx, m_wc, m_rc, m_rptr;
  bit          m_done, m_to, m_ov;
  logic [4:0]  m_le;
  bit          e_v, e_l, pend;
  logic [7:0]  e_b;
  logic [31:0] e_rd;

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; m_wptr = 0; m_cnt = 0; m_tmo = 0; m_idx = 0; m_wc = 0; m_rc = 0; m_rptr = 0;
      m_done = 0; m_to = 0; m_ov = 0; m_le = '0; e_v = 0; e_l = 0; e_b = '0; pend = 0; e_rd = '0;
      for (int i = 0; i < 32; i++) m_rxb[i] = 8'h00;
    end else begin
      int ms0;
      ms0 = ms;
      pend = reg_rd;
      if (reg_rd) begin
        if (reg_addr == 2'd0) e_rd = {m_tmo[15:0], 11'b0, m_cnt[4:0]};
        else if (reg_addr == 2'd1) begin
          e_rd = (m_rptr % 32 < 17) ? {16'h0, m_rxb[m_rptr % 32], 8'h00} : 32'h0;
          m_rptr++;
        end else begin
          e_rd = '0;
          e_rd[0] = m_done; e_rd[1] = (ms0 != 0); e_rd[2] = m_to; e_rd[3] = m_ov;
          e_rd[8:4] = m_le; e_rd[28:24] = m_rc[4:0];
        end
      end
      if (reg_wr && reg_addr == 2'd3 && reg_wdata[0]) m_done = 0;
      e_v = 0; e_l = 0;
      case (ms0)
        1: begin
          e_v = 1; e_b = m_txb[m_idx]; m_idx++;
          if (m_idx == m_cnt) begin e_l = 1; ms = 2; m_wc = 0; end
        end
        2: begin
          m_le = m_le | rx_err;
          if (rx_valid) begin
            m_rxb[0] = rx_byte; m_rc = 1;
            if (rx_end) begin m_done = 1; ms = 0; end else ms = 3;
          end else if (m_wc == m_tmo) begin
            m_done = 1; m_to = 1; ms = 0;
          end else m_wc++;
        end
        3: begin
          m_le = m_le | rx_err;
          if (rx_valid) begin
            if (m_rc < 17) begin m_rxb[m_rc] = rx_byte; m_rc++; end
            else m_ov = 1;
            if (rx_end) begin m_done = 1; ms = 0; end
          end
        end
        default: ;
      endcase
      if (reg_wr && reg_addr == 2'd0 && ms0 == 0) begin
        m_cnt = int'(reg_wdata[4:0]);
        m_tmo = int'(reg_wdata[31:16]);
        if (reg_wdata[8] && m_cnt >= 1 && m_cnt <= 20) begin
          ms = 1; m_idx = 0; m_done = 0; m_to = 0; m_ov = 0; m_le = '0; m_rc = 0;
        end
      end
      if (reg_wr && reg_addr == 2'd1) begin
        if (reg_wdata[30]) m_rptr = 0;
        else begin
          int p;
          p = reg_wdata[31] ? 0 : m_wptr;
          if (p < 20) begin m_txb[p] = reg_wdata[7:0]; m_wptr = p + 1; end
        end
      end
    end
  end

  // every-clock comparison of line outputs and read data
  always @(negedge clk) begin
    if (rst) begin
      chk(tx_valid == 1'b0 && tx_last == 1'b0, "R12", {30'b0, tx_valid, tx_last}, 32'h0);
    end else begin
      chk(tx_valid == e_v, "R1", {31'b0, tx_valid}, {31'b0, e_v});
      chk(tx_last == e_l, "R1", {31'b0, tx_last}, {31'b0, e_l});
      if (e_v) chk(tx_byte == e_b, "R1", {24'b0, tx_byte}, {24'b0, e_b});
      if (pend) chk(reg_rdata == e_rd, cur, reg_rdata, e_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] rbuf [0:31];

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input int cnt, input int tmo);
    wr(2'd0, (32'(tmo) << 16) | 32'h100 | 32'(cnt));
  endtask

  task automatic reply(input int n, input int ecyc, input logic [4:0] e);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_byte = rbuf[i]; rx_end = (i == n - 1);
      rx_err = (i == ecyc) ? e : 5'b0;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_end = 1'b0; rx_err = '0; rx_byte = '0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [31:0] v;
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    rx_valid = 0; rx_byte = '0; rx_end = 0; rx_err = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R12: reset state
    cur = "R12"; rd(2'd2, v); chk(v == 32'h0, "R12", v, 32'h0);

    // R2/R1: native write of two bytes to 0x0123
    cur = "R2";
    wr(2'd1, 32'h8000_0080); wr(2'd1, 32'h01); wr(2'd1, 32'h23);
    wr(2'd1, 32'h01); wr(2'd1, 32'hAA); wr(2'd1, 32'hBB);
    wr(2'd3, 32'h1);
    cur = "R1"; go(6, 50);
    cur = "R4"; go(3, 3);                       // ignored while busy
    cur = "R5"; rd(2'd0, v);
    chk(v[8] == 1'b0 && v[4:0] == 5'd6 && v[31:16] == 16'd50, "R4", v, 32'h0032_0006);
    rd(2'd2, v); chk(v[1] == 1'b1, "R5", v, 32'h2);
    idle(8);
    rbuf[0] = 8'h00; reply(1, -1, 5'b0);
    idle(2);
    cur = "R6"; rd(2'd2, v); chk(v == 32'h0100_0001, "R6", v, 32'h0100_0001);
    cur = "R11"; wr(2'd3, 32'h1); rd(2'd2, v); chk(v == 32'h0100_0000, "R11", v, 32'h0100_0000);

    // address-only read (three bytes)
    cur = "R1";
    wr(2'd1, 32'h8000_0090); wr(2'd1, 32'h00); wr(2'd1, 32'h10);
    go(3, 40); idle(6);
    rbuf[0] = 8'h00; reply(1, -1, 5'b0); idle(2);
    cur = "R6"; rd(2'd2, v); chk(v[28:24] == 5'd1 && v[0], "R6", v, 32'h0100_0001);

    // four-byte read, reply ack + four data bytes
    wr(2'd3, 32'h1);
    cur = "R1";
    wr(2'd1, 32'h8000_0090); wr(2'd1, 32'h02); wr(2'd1, 32'h00); wr(2'd1, 32'h03);
    go(4, 40); idle(8);
    rbuf[0] = 8'h00; rbuf[1] = 8'h11; rbuf[2] = 8'h22; rbuf[3] = 8'h33; rbuf[4] = 8'h44;
    reply(5, -1, 5'b0); idle(2);
    cur = "R7"; wr(2'd1, 32'h4000_0000);
    for (int i = 0; i < 5; i++) begin
      rd(2'd1, v); chk(v == {16'h0, rbuf[i], 8'h00}, "R7", v, {16'h0, rbuf[i], 8'h00});
    end

    // R3: out-of-range counts never start
    cur = "R3"; wr(2'd3, 32'h1);
    go(0, 40); idle(3); rd(2'd2, v); chk(v[1:0] == 2'b00, "R3", v, 32'h0100_0000);
    go(21, 40); idle(3); rd(2'd2, v); chk(v[1:0] == 2'b00, "R3", v, 32'h0100_0000);

    // R8: timeout with L = 5
    cur = "R8"; wr(2'd1, 32'h8000_0090);
    go(3, 5); idle(20);
    rd(2'd2, v); chk(v == 32'h0000_0005, "R8", v, 32'h0000_0005);

    // R9: overflow with 19 reply bytes
    cur = "R9"; wr(2'd3, 32'h1);
    go(3, 100); idle(5);
    for (int i = 0; i < 19; i++) rbuf[i] = 8'h40 + 8'(i);
    reply(19, -1, 5'b0); idle(2);
    rd(2'd2, v); chk(v == 32'h1100_0009, "R9", v, 32'h1100_0009);
    wr(2'd1, 32'h4000_0000);
    for (int i = 0; i < 17; i++) begin
      rd(2'd1, v); chk(v[15:8] == rbuf[i], "R9", v, {16'h0, rbuf[i], 8'h00});
    end

    // R10: line errors collected, then cleared by the next go
    cur = "R10"; wr(2'd3, 32'h1);
    go(3, 100); idle(5);
    rbuf[0] = 8'h00; rbuf[1] = 8'h5A;
    reply(2, 1, 5'b10010); idle(2);
    rd(2'd2, v); chk(v[8:4] == 5'b10010, "R10", v, 32'h0200_0121);
    go(3, 100); idle(1);
    rd(2'd2, v); chk(v[8:4] == 5'b0 && v[1], "R10", v, 32'h2);
    idle(5); rbuf[0] = 8'h00; reply(1, -1, 5'b0); idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule